// File: doc/BRIEF.md
# 6502-Style Bus Cycle Master

This block drives an external bus that follows the 6502 single read/write line protocol, one bus cycle at a time. A separate two-phase clock generator supplies one-clock strobes that mark the rising and falling edges of PHI2. Each falling edge of PHI2 is a cycle boundary. At that boundary the block starts the next cycle from a request taken through a valid/ready handshake. A request is an opcode fetch, a read or a write, and it carries an address, write data and an extra stretch count. When no request is waiting, the block runs an idle read of the address it last drove.

The block drives the address, the read/write line and the opcode-fetch marker. During writes it drives the data bus while PHI2 is high. On reads it leaves the bus tri-stated and captures the byte at the PHI2 fall that ends the cycle. Each completed fetch or read returns the byte and its request type on a response port. A low ready input extends a fetch or read cycle, and the per-request stretch count adds whole PHI2 periods to any cycle. Three asynchronous pins are synchronised into level flags: an active-low maskable interrupt, an active-low non-maskable interrupt and an active-high set-overflow input. The requester decodes instructions and produces any vector addresses.

Top module: `bus6502_master`

## Requirements
- R1: `req_ready_o` is high only in a clock where `ph2_fall_i` is high and the current cycle has no wait or stretch pending. A request is taken only when `req_valid_i` is also high. The address, `bus_rnw_o` and `bus_sync_o` change only in the clock after a PHI2 fall strobe that ends a cycle.
- R2: Request kind codes are 00 for read, 01 for opcode fetch and 10 for write. `bus_rnw_o` is 1 during fetch and read cycles and 0 during write cycles.
- R3: `bus_sync_o` is 1 only during an opcode fetch cycle and 0 during reads, writes and idle cycles.
- R4: When a fetch or read cycle ends, `bus_din_i` is captured in the clock of the ending PHI2 fall strobe. `rsp_valid_o` is then high for exactly one clock, with that byte on `rsp_data_o` and the request kind code on `rsp_kind_o`.
- R5: In a write cycle, `bus_doe_o` rises in the clock after each PHI2 rise strobe and falls in the clock after each PHI2 fall strobe, and `bus_dout_o` carries the request's write data. `bus_doe_o` stays 0 in read, fetch and idle cycles.
- R6: If `bus_rdy_i` is 0 at a PHI2 rise strobe in a fetch, read or idle cycle, the next PHI2 fall does not end the cycle, and the level is sampled again at the following rise. `bus_rdy_i` has no effect on write cycles.
- R7: A request with stretch count N lasts N+1 PHI2 periods when no ready wait is added.
- R8: If no request is valid at a boundary, the next cycle is an idle read of the last driven address. It has `bus_rnw_o`=1 and `bus_sync_o`=0, and it produces no response.
- R9: `irq_flag_o` is 1 while `irq_n_i` is 0, `nmi_flag_o` is 1 while `nmi_n_i` is 0, and `so_flag_o` is 1 while `so_i` is 1. Each flag follows its pin after SYNC_STAGES clocks.
- R10: After reset, the block runs an idle read of address 0000: `bus_rnw_o`=1, `bus_sync_o`=0, `bus_doe_o`=0, and `rsp_valid_o`=0. All flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph2_rise_i | input | 1 | One-clock strobe at PHI2 rise |
| ph2_fall_i | input | 1 | One-clock strobe at PHI2 fall (cycle boundary) |
| req_valid_i | input | 1 | Request waiting |
| req_ready_o | output | 1 | Request taken this clock |
| req_kind_i | input | 2 | 00 read, 01 fetch, 10 write |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_stretch_i | input | 4 | Extra PHI2 periods for this cycle |
| bus_addr_o | output | 16 | Address bus |
| bus_rnw_o | output | 1 | 1 read/fetch, 0 write |
| bus_sync_o | output | 1 | Opcode-fetch marker |
| bus_dout_o | output | 8 | Data bus output value |
| bus_doe_o | output | 1 | Data bus output enable |
| bus_din_i | input | 8 | Data bus input value |
| bus_rdy_i | input | 1 | Ready; low extends a read |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_kind_o | output | 2 | Kind code of completed cycle |
| rsp_data_o | output | 8 | Captured byte |
| irq_n_i | input | 1 | Maskable interrupt pin, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, active low |
| so_i | input | 1 | Set-overflow pin, active high |
| irq_flag_o | output | 1 | Interrupt level flag |
| nmi_flag_o | output | 1 | Non-maskable interrupt level flag |
| so_flag_o | output | 1 | Set-overflow level flag |

## Verification
The assertions assume that the phase strobes are single-clock pulses, that a rise and a fall never coincide, and that a rise falls between any two falls. They also assume that two fall strobes are never in adjacent clocks, so a response pulse can always return low. The bench makes every strobe from one task that surrounds each pulse with idle clocks and alternates rises with falls. Request fields are changed only away from fall strobes, and the data and ready inputs are set before the strobe that samples them.

// File: rtl/bm6502_pkg.sv
package bm6502_pkg;
    localparam int BM_ADDR_W = 16;
    localparam int BM_DATA_W = 8;
    localparam int BM_STR_W  = 4;

    localparam logic [1:0] BM_RD    = 2'b00;
    localparam logic [1:0] BM_FETCH = 2'b01;
    localparam logic [1:0] BM_WR    = 2'b10;

    // Unknown code 11 is treated as a plain read.
    function automatic logic [1:0] bm_norm_kind(input logic [1:0] k);
        return (k == BM_FETCH || k == BM_WR) ? k : BM_RD;
    endfunction
endpackage

// File: rtl/bm_pin_flag.sv
module bm_pin_flag #(
    parameter int   STAGES     = 2,
    parameter logic ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic flag_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              pin_act;

    assign pin_act = ACTIVE_LOW ? ~pin_i : pin_i;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = pin_act;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], pin_act};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign flag_o = sync_q[STAGES-1];
endmodule

// File: rtl/bm_wait_ctl.sv
module bm_wait_ctl #(
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph2_rise_i,
    input  logic             ph2_fall_i,
    input  logic             rnw_i,
    input  logic             rdy_i,
    input  logic             load_i,
    input  logic [STR_W-1:0] load_stretch_i,
    output logic             cyc_end_o
);
    typedef struct packed {
        logic             hold;
        logic [STR_W-1:0] left;
    } wait_t;

    wait_t d, q;

    always_comb begin
        d = q;
        if (ph2_rise_i) begin
            d.hold = rnw_i & ~rdy_i;
        end
        if (ph2_fall_i && !q.hold && q.left != '0) begin
            d.left = q.left - 1'b1;
        end
        if (load_i) begin
            d.hold = 1'b0;
            d.left = load_stretch_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cyc_end_o = ~q.hold && (q.left == '0);

    AST_WRITE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_rise_i && !rnw_i) |=> !q.hold); // R6
    AST_LEFT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2_fall_i |=> $stable(q.left)); // R7
endmodule

// File: rtl/bm_cycle_seq.sv
module bm_cycle_seq
    import bm6502_pkg::*;
#(
    parameter int ADDR_W = BM_ADDR_W,
    parameter int DATA_W = BM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph2_rise_i,
    input  logic              ph2_fall_i,
    input  logic              cyc_end_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rnw_o,
    output logic              bus_sync_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              rsp_valid_o,
    output logic [1:0]        rsp_kind_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        kind;
        logic              idle;
        logic              doe;
        logic              rsp_valid;
        logic [1:0]        rsp_kind;
        logic [DATA_W-1:0] rsp_data;
    } seq_t;

    seq_t d, q;
    logic boundary;
    logic is_rd;

    assign boundary = ph2_fall_i & cyc_end_i;
    assign is_rd    = (q.kind != BM_WR);

    always_comb begin
        d = q;
        d.rsp_valid = 1'b0;
        if (ph2_rise_i) begin
            d.doe = ~is_rd;
        end
        if (ph2_fall_i) begin
            d.doe = 1'b0;
        end
        if (boundary) begin
            if (is_rd && !q.idle) begin
                d.rsp_valid = 1'b1;
                d.rsp_kind  = q.kind;
                d.rsp_data  = bus_din_i;
            end
            if (req_valid_i) begin
                d.addr  = req_addr_i;
                d.wdata = req_wdata_i;
                d.kind  = bm_norm_kind(req_kind_i);
                d.idle  = 1'b0;
            end else begin
                d.kind  = BM_RD;
                d.idle  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.idle <= 1'b1;
            q.kind <= BM_RD;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = boundary;
    assign bus_addr_o  = q.addr;
    assign bus_rnw_o   = is_rd;
    assign bus_sync_o  = (q.kind == BM_FETCH) && !q.idle;
    assign bus_dout_o  = q.wdata;
    assign bus_doe_o   = q.doe;
    assign rsp_valid_o = q.rsp_valid;
    assign rsp_kind_o  = q.rsp_kind;
    assign rsp_data_o  = q.rsp_data;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph2_rise_i && ph2_fall_i)); // R1
    AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> ph2_fall_i); // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph2_fall_i |=> $stable(bus_addr_o)); // R1
    AST_SYNC_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sync_o |-> bus_rnw_o); // R3
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe_o |-> !bus_rnw_o); // R5
    AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_fall_i |=> !bus_doe_o); // R5
    AST_RSP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(ph2_fall_i)); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o); // R4
endmodule

// File: rtl/bus6502_master.sv
module bus6502_master
    import bm6502_pkg::*;
#(
    parameter int ADDR_W      = BM_ADDR_W,
    parameter int DATA_W      = BM_DATA_W,
    parameter int STR_W       = BM_STR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph2_rise_i,
    input  logic              ph2_fall_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [STR_W-1:0]  req_stretch_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rnw_o,
    output logic              bus_sync_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    input  logic [DATA_W-1:0] bus_din_i,
    input  logic              bus_rdy_i,
    output logic              rsp_valid_o,
    output logic [1:0]        rsp_kind_o,
    output logic [DATA_W-1:0] rsp_data_o,
    input  logic              irq_n_i,
    input  logic              nmi_n_i,
    input  logic              so_i,
    output logic              irq_flag_o,
    output logic              nmi_flag_o,
    output logic              so_flag_o
);
    localparam int         NPIN    = 3;
    localparam logic [2:0] PIN_LOW = 3'b011;

    logic             cyc_end;
    logic             ready;
    logic [STR_W-1:0] load_stretch;
    logic [NPIN-1:0]  pin_raw;
    logic [NPIN-1:0]  pin_flag;

    assign load_stretch = req_valid_i ? req_stretch_i : '0;
    assign req_ready_o  = ready;

    bm_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph2_rise_i  (ph2_rise_i),
        .ph2_fall_i  (ph2_fall_i),
        .cyc_end_i   (cyc_end),
        .req_valid_i (req_valid_i),
        .req_ready_o (ready),
        .req_kind_i  (req_kind_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .bus_addr_o  (bus_addr_o),
        .bus_rnw_o   (bus_rnw_o),
        .bus_sync_o  (bus_sync_o),
        .bus_dout_o  (bus_dout_o),
        .bus_doe_o   (bus_doe_o),
        .bus_din_i   (bus_din_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_kind_o  (rsp_kind_o),
        .rsp_data_o  (rsp_data_o)
    );

    bm_wait_ctl #(.STR_W(STR_W)) u_wait (
        .clk            (clk),
        .rst_n          (rst_n),
        .ph2_rise_i     (ph2_rise_i),
        .ph2_fall_i     (ph2_fall_i),
        .rnw_i          (bus_rnw_o),
        .rdy_i          (bus_rdy_i),
        .load_i         (ready),
        .load_stretch_i (load_stretch),
        .cyc_end_o      (cyc_end)
    );

    assign pin_raw = {so_i, nmi_n_i, irq_n_i};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            bm_pin_flag #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(PIN_LOW[g])) u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (pin_raw[g]),
                .flag_o (pin_flag[g])
            );
        end
    endgenerate

    assign irq_flag_o = pin_flag[0];
    assign nmi_flag_o = pin_flag[1];
    assign so_flag_o  = pin_flag[2];
endmodule

// File: tb/tb_bus6502_master.sv
`timescale 1ns/1ps
module tb_bus6502_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph2_rise = 1'b0, ph2_fall = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [3:0]  req_stretch = '0;
    logic [15:0] bus_addr;
    logic        bus_rnw, bus_sync, bus_doe;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din = '0;
    logic        bus_rdy = 1'b1;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [7:0]  rsp_data;
    logic        irq_n = 1'b1, nmi_n = 1'b1, so = 1'b0;
    logic        irq_flag, nmi_flag, so_flag;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bus6502_master dut (
        .clk(clk), .rst_n(rst_n), .ph2_rise_i(ph2_rise), .ph2_fall_i(ph2_fall),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_stretch_i(req_stretch),
        .bus_addr_o(bus_addr), .bus_rnw_o(bus_rnw), .bus_sync_o(bus_sync),
        .bus_dout_o(bus_dout), .bus_doe_o(bus_doe), .bus_din_i(bus_din),
        .bus_rdy_i(bus_rdy), .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind),
        .rsp_data_o(rsp_data), .irq_n_i(irq_n), .nmi_n_i(nmi_n), .so_i(so),
        .irq_flag_o(irq_flag), .nmi_flag_o(nmi_flag), .so_flag_o(so_flag)
    );

    // vld, kind, addr, wdata, stretch, rdy-low rises, read data
    typedef struct packed {
        logic        vld;
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [3:0]  st;
        logic [1:0]  low;
        logic [7:0]  din;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 2'b01, 16'h8000, 8'h00, 4'd0, 2'd0, 8'hA9},
        '{1'b1, 2'b00, 16'h1234, 8'h00, 4'd0, 2'd2, 8'h5A},
        '{1'b1, 2'b10, 16'h0200, 8'h3C, 4'd0, 2'd0, 8'h00},
        '{1'b0, 2'b00, 16'h0000, 8'h00, 4'd0, 2'd0, 8'h00},
        '{1'b1, 2'b00, 16'hFFFC, 8'h00, 4'd2, 2'd0, 8'h77},
        '{1'b1, 2'b10, 16'h0300, 8'hC3, 4'd0, 2'd1, 8'h00},
        '{1'b1, 2'b01, 16'hC000, 8'h00, 4'd1, 2'd1, 8'hEE},
        '{1'b1, 2'b00, 16'h00FF, 8'h00, 4'd0, 2'd0, 8'h01},
        '{1'b0, 2'b00, 16'h0000, 8'h00, 4'd0, 2'd0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_rise(input logic rdy);
        @(negedge clk);
        bus_rdy  = rdy;
        ph2_rise = 1'b1;
        @(negedge clk);
        ph2_rise = 1'b0;
    endtask

    task automatic do_fall(output logic rdy_seen);
        @(negedge clk);
        ph2_fall = 1'b1;
        #1;
        rdy_seen = req_ready;
        @(negedge clk);
        ph2_fall  = 1'b0;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic        seen;
        logic        exp_rv;
        logic [7:0]  exp_rd;
        logic [1:0]  exp_rk;
        logic [15:0] last_addr;
        exp_rv = 1'b0; exp_rd = '0; exp_rk = '0; last_addr = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 addr", bus_addr, 16'h0000);
        chk("R10 rnw", bus_rnw, 1);
        chk("R10 sync", bus_sync, 0);
        chk("R10 doe", bus_doe, 0);
        chk("R10 rsp", rsp_valid, 0);
        chk("R10 flags", {irq_flag, nmi_flag, so_flag}, 0);

        // R1: no acceptance away from a fall strobe
        req_valid = 1'b1;
        #1;
        chk("R1 ready without strobe", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic wr;
            int   np;
            v = VEC[i];
            req_valid   = v.vld;
            req_kind    = v.kind;
            req_addr    = v.addr;
            req_wdata   = v.wd;
            req_stretch = v.st;
            do_fall(seen);
            chk("R1 ready at boundary", seen, 1);
            chk("R4 rsp valid", rsp_valid, exp_rv);
            if (exp_rv) begin
                chk("R4 rsp data", rsp_data, exp_rd);
                chk("R4 rsp kind", rsp_kind, exp_rk);
                @(negedge clk);
                chk("R4 single pulse", rsp_valid, 0);
            end
            if (v.vld) last_addr = v.addr;
            wr = v.vld && (v.kind == 2'b10);
            chk("R1 addr", bus_addr, last_addr);
            chk(v.vld ? "R2 rnw" : "R8 idle rnw", bus_rnw, !wr);
            chk(v.vld ? "R3 sync" : "R8 idle sync", bus_sync, v.vld && v.kind == 2'b01);
            bus_din = v.din;
            np = 1 + int'(v.st) + (wr ? 0 : int'(v.low));
            for (int r = 0; r < np; r++) begin
                do_rise(r < int'(v.low) ? 1'b0 : 1'b1);
                chk("R5 oe high phase", bus_doe, wr);
                if (wr) chk("R5 dout", bus_dout, v.wd);
                if (r < np - 1) begin
                    do_fall(seen);
                    chk(v.low != 0 ? "R6 wait no end" : "R7 stretch no end", seen, 0);
                    chk("R5 oe dropped", bus_doe, 0);
                    chk("R4 no early rsp", rsp_valid, 0);
                    chk("R1 addr held", bus_addr, last_addr);
                end
            end
            exp_rv = v.vld && !wr;
            exp_rd = v.din;
            exp_rk = v.kind;
        end
        do_fall(seen);
        chk("R8 idle ends", seen, 1);
        chk("R8 idle no rsp", rsp_valid, 0);

        // R9 pin flags
        irq_n = 1'b0;
        @(negedge clk);
        chk("R9 irq lag", irq_flag, 0);
        @(negedge clk);
        chk("R9 irq set", irq_flag, 1);
        irq_n = 1'b1; nmi_n = 1'b0; so = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 irq clear", irq_flag, 0);
        chk("R9 nmi set", nmi_flag, 1);
        chk("R9 so set", so_flag, 1);
        nmi_n = 1'b1; so = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 all clear", {irq_flag, nmi_flag, so_flag}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule